// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a fixed reference clock-enable (nominally 3 MHz) into a one-cycle baud tick. The bit period, counted in reference enables, is a divisor made of an integer part `n` and a fraction `x` counted in eighths. A 3-bit eighths accumulator adds `x` at the start of each period. When that addition carries out, the period gets one extra reference enable. The fractional part is therefore spread over the periods, and the long-run rate is exactly reference / (n + x/8).

A divisor is loaded with a one-cycle strobe. A legal divisor arms the generator, and the next reference enable starts a fresh period with a cleared accumulator. An illegal divisor raises an error flag and stops all ticks until a legal one is loaded. The length of the period in progress is shown on an output so that it can be checked.

Control is a four-state machine:
- **IDLE**: after reset, no divisor has been loaded.
- **ARM**: a legal divisor is held and the generator is waiting for the reference enable that starts the first period.
- **RUN**: periods are being counted and ticks are issued.
- **FAULT**: an illegal divisor was loaded.

Transitions:
- A load from any state goes to ARM if the divisor is legal and to FAULT if it is not.
- ARM goes to RUN on a reference enable that has no load in the same cycle.
- IDLE, RUN and FAULT otherwise hold.

Top module: `frac_baud_gen`

## Requirements
- R1: For a legal divisor with 2 <= n <= 16384 and any fraction, each period lasts either n or n+1 reference enables.
- R2: The fraction `div_frac` counts eighths (0..7). Each period start adds it to a 3-bit accumulator. A carry out of bit 2 lengthens that period by one. Any 8 consecutive periods after a load total exactly 8n + x reference enables.
- R3: n = 1 with x = 0 is legal. It gives one tick for every reference enable.
- R4: A divisor is illegal when n = 0, when n = 1 with x != 0, or when n > 16384. `div_err` is high from the cycle after such a load, and no tick occurs. A legal load drives `div_err` low in the cycle after it.
- R5: After a legal load, the first reference enable starts a fresh period and is not counted. The accumulator restarts from zero, so the first period lasts n enables.
- R6: `baud_tick` is high for exactly the one clock after the reference enable that completes a period, and low otherwise.
- R7: `period_len` reads 0 in the cycle after any load. It then shows the length of the period in progress, updated in the cycle after each period starts.
- R8: After reset, `baud_tick` and `div_err` are low and `period_len` is 0. No tick occurs before a divisor is loaded.
- R9: When a load and a reference enable fall in the same cycle, the load wins and that enable is neither counted nor used to start a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 1 | Reference clock-enable, one pulse per reference tick |
| div_load | input | 1 | One-cycle strobe that captures a new divisor |
| div_int | input | 15 | Integer part n of the divisor |
| div_frac | input | 3 | Fractional part in eighths |
| baud_tick | output | 1 | One-cycle tick at the end of each bit period |
| div_err | output | 1 | High while an illegal divisor is loaded |
| period_len | output | 15 | Length in reference enables of the period in progress |

## Verification
The hardest case to reach is the one where the accumulator wraps and the period is stretched. Checking it also needs the exact count of reference enables between ticks while the enables arrive with irregular gaps. The bench therefore gates the reference enable randomly. It counts every enable it drives and compares each observed period with a model that steps its own eighths accumulator. It also sums groups of eight periods. Directed cases cover:
- the largest fraction at n = 2 and at the maximum integer;
- the divisor of one;
- loads that land in the middle of a period, or in the same cycle as an enable.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_ARM,
        S_RUN,
        S_FAULT
    } fbg_state_e;
endpackage

// File: rtl/fbg_div_check.sv
module fbg_div_check #(
    parameter int MAX_INT = 16384,
    parameter int INT_W   = 15,
    parameter int FRAC_W  = 3
) (
    input  logic [INT_W-1:0]  n,
    input  logic [FRAC_W-1:0] x,
    output logic              legal
);
    localparam logic [INT_W-1:0] N_ONE = INT_W'(1);
    localparam logic [INT_W-1:0] N_MIN = INT_W'(2);
    localparam logic [INT_W-1:0] N_MAX = INT_W'(MAX_INT);

    always_comb begin
        legal = ((n == N_ONE) && (x == '0)) || ((n >= N_MIN) && (n <= N_MAX));
    end
endmodule

// File: rtl/fbg_frac_acc.sv
module fbg_frac_acc #(
    parameter int FRAC_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [FRAC_W-1:0] x,
    output logic              carry
);
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;

    always_comb begin
        sum   = {1'b0, (clear ? {FRAC_W{1'b0}} : acc_q)} + {1'b0, x};
        carry = sum[FRAC_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clear || step) begin
            acc_q <= sum[FRAC_W-1:0];
        end
    end
endmodule

// File: rtl/fbg_period_cnt.sv
module fbg_period_cnt #(
    parameter int LEN_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             adv,
    input  logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] count,
    output logic             wrap
);
    logic [LEN_W-1:0] count_q;

    always_comb begin
        wrap  = adv && (count_q == (len - LEN_W'(1)));
        count = count_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (restart) begin
            count_q <= '0;
        end else if (adv) begin
            count_q <= wrap ? '0 : count_q + LEN_W'(1);
        end
    end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
    parameter int MAX_INT = 16384,
    parameter int FRAC_W  = 3,
    localparam int INT_W  = $clog2(MAX_INT + 1),
    localparam int LEN_W  = $clog2(MAX_INT + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_en,
    input  logic              div_load,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              baud_tick,
    output logic              div_err,
    output logic [LEN_W-1:0]  period_len
);
    import fbg_pkg::*;

    fbg_state_e        state_q, state_d;
    logic [INT_W-1:0]  cfg_n;
    logic [FRAC_W-1:0] cfg_x;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  cnt;
    logic              legal, carry, wrap, arm_go, run_adv;

    fbg_div_check #(.MAX_INT(MAX_INT), .INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
        .n(div_int), .x(div_frac), .legal(legal)
    );

    always_comb begin
        arm_go  = (state_q == S_ARM) && ref_en && !div_load;
        run_adv = (state_q == S_RUN) && ref_en && !div_load;
    end

    fbg_frac_acc #(.FRAC_W(FRAC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clear(arm_go), .step(wrap),
        .x(cfg_x), .carry(carry)
    );

    fbg_period_cnt #(.LEN_W(LEN_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .restart(arm_go), .adv(run_adv),
        .len(len_q), .count(cnt), .wrap(wrap)
    );

    always_comb begin
        state_d = state_q;
        if (div_load) begin
            state_d = legal ? S_ARM : S_FAULT;
        end else begin
            unique case (state_q)
                S_IDLE:  state_d = S_IDLE;
                S_ARM:   state_d = ref_en ? S_RUN : S_ARM;
                S_RUN:   state_d = S_RUN;
                S_FAULT: state_d = S_FAULT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_n <= '0;
            cfg_x <= '0;
            len_q <= '0;
        end else if (div_load) begin
            cfg_n <= div_int;
            cfg_x <= div_frac;
            len_q <= '0;
        end else if (arm_go || wrap) begin
            len_q <= LEN_W'(cfg_n) + LEN_W'(carry);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            baud_tick <= 1'b0;
            div_err   <= 1'b0;
        end else begin
            baud_tick <= wrap;
            div_err   <= (state_d == S_FAULT);
        end
    end

    always_comb period_len = len_q;

    AST_ERR_BLOCKS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        div_err |-> !baud_tick); // R4
    AST_ERR_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_err) |-> $past(div_load)); // R4
    AST_TICK_FROM_REF: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> $past(ref_en)); // R6
    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN) |-> ((period_len == LEN_W'(cfg_n)) ||
                                (period_len == LEN_W'(cfg_n) + LEN_W'(1)))); // R1
    AST_CNT_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN) |-> (cnt < period_len)); // R1
endmodule

// File: tb/sim_frac_baud_gen.sv
module sim_frac_baud_gen;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ref_en;
    logic        div_load;
    logic [14:0] div_int;
    logic [2:0]  div_frac;
    logic        baud_tick;
    logic        div_err;
    logic [14:0] period_len;
    int          n_chk = 0;
    int          n_bad = 0;

    always #10 clk = ~clk;

    frac_baud_gen u0 (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .div_load(div_load),
        .div_int(div_int), .div_frac(div_frac), .baud_tick(baud_tick),
        .div_err(div_err), .period_len(period_len)
    );

    function automatic bit legal_div(int n, int x);
        return ((n == 1) && (x == 0)) || ((n >= 2) && (n <= 16384));
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic load(int n, int x, bit with_ref);
        @(negedge clk);
        div_int  = 15'(n);
        div_frac = 3'(x);
        div_load = 1'b1;
        ref_en   = with_ref;
        @(negedge clk);
        div_load = 1'b0;
        ref_en   = 1'b0;
        check(div_err == !legal_div(n, x), "R4", "div_err after load", int'(div_err), int'(!legal_div(n, x)));
        check(period_len == 0, "R7", "period_len after load", int'(period_len), 0);
        check(baud_tick == 1'b0, "R9", "tick in load cycle", int'(baud_tick), 0);
    endtask

    task automatic run_legal(int n, int x, int periods, int extra, string req);
        int acc;
        int sum;
        int exp_len;
        int cnt;
        int seen;
        int tot;
        int grp;
        acc = 0; cnt = 0; seen = 0; tot = 0; grp = 0;
        ref_en = 1'b1;
        @(negedge clk);
        ref_en = 1'b0;
        sum = acc + x;
        exp_len = n + ((sum >= 8) ? 1 : 0);
        acc = sum % 8;
        check(baud_tick == 1'b0, "R5", "no tick on start enable", int'(baud_tick), 0);
        check(period_len == 15'(exp_len), "R5", "first period length", int'(period_len), exp_len);
        while (seen < periods) begin
            bit r;
            r = (($urandom % 4) != 0);
            ref_en = r;
            if (r) cnt++;
            @(negedge clk);
            ref_en = 1'b0;
            if (baud_tick) begin
                check(cnt == exp_len, req, "period length", cnt, exp_len);
                tot += cnt;
                seen++;
                grp++;
                if (grp == 8) begin
                    check(tot == 8 * n + x, "R2", "eight-period total", tot, 8 * n + x);
                    grp = 0;
                    tot = 0;
                end
                sum = acc + x;
                exp_len = n + ((sum >= 8) ? 1 : 0);
                acc = sum % 8;
                cnt = 0;
                check(period_len == 15'(exp_len), "R7", "period_len after tick", int'(period_len), exp_len);
                @(negedge clk);
                check(baud_tick == 1'b0, "R6", "tick width", int'(baud_tick), 0);
            end else if (cnt >= exp_len) begin
                check(1'b0, req, "missing tick", cnt, exp_len);
                return;
            end
        end
        for (int k = 0; k < extra; k++) begin
            ref_en = 1'b1;
            @(negedge clk);
        end
        ref_en = 1'b0;
    endtask

    task automatic illegal_run(int n, int x);
        int ticks;
        ticks = 0;
        load(n, x, 1'b0);
        for (int k = 0; k < 40; k++) begin
            ref_en = 1'b1;
            @(negedge clk);
            if (baud_tick) ticks++;
        end
        ref_en = 1'b0;
        check(ticks == 0, "R4", "ticks under illegal divisor", ticks, 0);
        check(div_err == 1'b1, "R4", "div_err held", int'(div_err), 1);
        check(period_len == 0, "R4", "period_len under illegal divisor", int'(period_len), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        int ticks;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; ref_en = 1'b0; div_load = 1'b0; div_int = '0; div_frac = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(baud_tick == 1'b0, "R8", "tick after reset", int'(baud_tick), 0);
        check(div_err == 1'b0, "R8", "div_err after reset", int'(div_err), 0);
        check(period_len == 0, "R8", "period_len after reset", int'(period_len), 0);
        ticks = 0;
        for (int k = 0; k < 20; k++) begin
            ref_en = 1'b1;
            @(negedge clk);
            if (baud_tick) ticks++;
        end
        ref_en = 1'b0;
        check(ticks == 0, "R8", "ticks before any load", ticks, 0);

        load(5, 3, 1'b0);
        run_legal(5, 3, 16, 3, "R1");
        load(2, 7, 1'b0);
        run_legal(2, 7, 8, 1, "R2");
        load(1, 0, 1'b0);
        run_legal(1, 0, 12, 2, "R3");
        illegal_run(1, 3);
        illegal_run(0, 0);
        illegal_run(16385, 0);
        load(7, 5, 1'b1);
        run_legal(7, 5, 8, 0, "R9");
        for (int i = 0; i < 10; i++) begin
            int n;
            int x;
            n = 2 + int'($urandom % 40);
            x = int'($urandom % 8);
            load(n, x, 1'b0);
            run_legal(n, x, 8, int'($urandom % 5), "R1");
        end
        load(16384, 7, 1'b0);
        run_legal(16384, 7, 2, 0, "R1");
        report();
        $finish;
    end
endmodule